// File: doc/BRIEF.md
# Magnitude-Density Gain Loop

This block closes a digital gain loop around a coarse quantiser. Each channel (I and Q) delivers one magnitude bit per sample clock. Over a fixed window of sample clocks the block counts how many samples had that bit set. It compares the count with a programmed reference and nudges a 6-bit amplifier gain code one step toward the point where the count matches the reference. With a reference of 170 in a 512-sample window, the loop settles near one third of samples showing magnitude, which suits a 2-bit quantiser.

There are four operating modes. In the first, the I and Q loops run separately. In the second, one shared code drives both channels, steered by the sum of the two counts. In the third, the code is taken straight from a programmed value. The fourth freezes both codes. When the Q channel is disabled, only the I code is ever updated. Any mode change restarts the window, so a window that has been cut short is never judged.

Top module: `mag_agc`

## Requirements
- R1: During reset and on release, both gain codes equal the parameter RESET_GAIN (default 58, binary 111010), and a fresh window begins on the first clock after reset.
- R2: In the loop modes (mode 00 and 01) a gain code changes only on the clock edge that takes in the last of WIN_LEN (default 512) consecutive samples, and every one of those samples counts.
- R3: At the end of a window, a count below the reference raises the code by one, a count above it lowers the code by one, and an equal count leaves the code unchanged.
- R4: A code saturates: it never goes above 63 or below 0, and it never wraps around.
- R5: Mode 00 (independent): the I code follows the I count and the Q code follows the Q count, each compared with the reference.
- R6: Mode 01 (locked) with Q enabled: the I and Q counts are added and compared with twice the reference. The I code is stepped, and the result is written to both codes, which are then equal.
- R7: Mode 10 (direct): on every clock edge the codes load direct_gain, so the output shows it one cycle later.
- R8: Mode 11: both codes hold their value.
- R9: With iq_en low, the Q code holds in every mode. The I code behaves as in independent mode (in modes 00 and 01) or as in direct mode (in mode 10).
- R10: When the mode input differs from its value on the previous edge, the window counter and the counts restart, and the sample on that edge is dropped. No partial window ever moves a gain code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 independent, 01 locked, 10 direct, 11 hold |
| iq_en | input | 1 | Enables the Q channel |
| ref_count | input | 12 | Target count of magnitude-set samples per window |
| direct_gain | input | 6 | Gain code used in direct mode |
| mag_i | input | 1 | I-channel magnitude bit |
| mag_q | input | 1 | Q-channel magnitude bit |
| gain_i | output | 6 | I-channel gain code (registered) |
| gain_q | output | 6 | Q-channel gain code (registered) |

## Verification
Properties check the following on every cycle: a code moves by at most one step and never wraps; outside direct mode it changes only at a window end; mode 11 and a disabled Q channel leave the relevant codes still; the locked mode leaves the two codes equal; direct mode loads the programmed value; and a restart zeroes the window counter. Other behaviour can only be shown by the directed scenarios. These cover the direction of each step against the exact count, the boundary where the count equals the reference, the use of the summed count against twice the reference in locked mode, and the fact that a window cut short by a mode change is never evaluated.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [1:0] {
    AGC_SPLIT  = 2'b00,
    AGC_LOCK   = 2'b01,
    AGC_DIRECT = 2'b10,
    AGC_FREEZE = 2'b11
  } agc_mode_e;

endpackage

// File: rtl/agc_window_timer.sv
module agc_window_timer #(
  parameter int WIN_LEN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic win_end
);
  localparam int CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign win_end = (cnt == LAST) && !restart;

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  a_r10_restart_zero: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
endmodule

// File: rtl/agc_mag_counter.sv
module agc_mag_counter #(
  parameter int WIN_LEN = 512,
  localparam int CNT_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             win_end,
  input  logic             mag,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clear || win_end) acc <= '0;
    else if (mag)                acc <= acc + 1'b1;
  end

  // Total for the window, including the sample presented on this edge.
  assign count = acc + {{(CNT_W-1){1'b0}}, mag};

  a_r2_acc_bound: assert property (@(posedge clk) disable iff (rst)
    acc < CNT_W'(WIN_LEN));
endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step #(
  parameter int GAIN_W = 6,
  parameter int MEAS_W = 13
) (
  input  logic [GAIN_W-1:0] cur_gain,
  input  logic [MEAS_W-1:0] measured,
  input  logic [MEAS_W-1:0] target,
  output logic [GAIN_W-1:0] next_gain
);
  localparam logic [GAIN_W-1:0] TOP = '1;

  always_comb begin
    next_gain = cur_gain;
    if (measured < target) begin
      if (cur_gain != TOP) next_gain = cur_gain + 1'b1;
    end else if (measured > target) begin
      if (cur_gain != '0) next_gain = cur_gain - 1'b1;
    end
  end
endmodule

// File: rtl/mag_agc.sv
module mag_agc
  import agc_pkg::*;
#(
  parameter int GAIN_W     = 6,
  parameter int REF_W      = 12,
  parameter int WIN_LEN    = 512,
  parameter int RESET_GAIN = 58
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              iq_en,
  input  logic [REF_W-1:0]  ref_count,
  input  logic [GAIN_W-1:0] direct_gain,
  input  logic              mag_i,
  input  logic              mag_q,
  output logic [GAIN_W-1:0] gain_i,
  output logic [GAIN_W-1:0] gain_q
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);
  localparam int CMP_W = ((REF_W + 1) > (CNT_W + 1)) ? (REF_W + 1) : (CNT_W + 1);
  localparam logic [GAIN_W-1:0] TOP  = '1;
  localparam logic [GAIN_W-1:0] INIT = GAIN_W'(RESET_GAIN);

  agc_mode_e mode_e, mode_q;
  logic      restart, win_end;

  assign mode_e = agc_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= AGC_SPLIT;
    else     mode_q <= mode_e;
  end

  assign restart = (mode_e != mode_q);

  agc_window_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .win_end(win_end)
  );

  logic [1:0]       mag_vec;
  logic [CNT_W-1:0] cnt [2];

  assign mag_vec = {mag_q, mag_i};

  for (genvar c = 0; c < 2; c++) begin : g_chan
    agc_mag_counter #(.WIN_LEN(WIN_LEN)) u_cnt (
      .clk(clk), .rst(rst), .clear(restart), .win_end(win_end),
      .mag(mag_vec[c]), .count(cnt[c])
    );
  end

  logic [CMP_W-1:0]  meas_i, meas_q, meas_sum, tgt_one, tgt_two;
  logic [GAIN_W-1:0] step_i, step_q, step_lock;

  assign meas_i   = CMP_W'(cnt[0]);
  assign meas_q   = CMP_W'(cnt[1]);
  assign meas_sum = meas_i + meas_q;
  assign tgt_one  = CMP_W'(ref_count);
  assign tgt_two  = CMP_W'({ref_count, 1'b0});

  agc_gain_step #(.GAIN_W(GAIN_W), .MEAS_W(CMP_W)) u_step_i (
    .cur_gain(gain_i), .measured(meas_i), .target(tgt_one), .next_gain(step_i)
  );
  agc_gain_step #(.GAIN_W(GAIN_W), .MEAS_W(CMP_W)) u_step_q (
    .cur_gain(gain_q), .measured(meas_q), .target(tgt_one), .next_gain(step_q)
  );
  agc_gain_step #(.GAIN_W(GAIN_W), .MEAS_W(CMP_W)) u_step_lock (
    .cur_gain(gain_i), .measured(meas_sum), .target(tgt_two), .next_gain(step_lock)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_i <= INIT;
      gain_q <= INIT;
    end else begin
      unique case (mode_e)
        AGC_SPLIT: if (win_end) begin
          gain_i <= step_i;
          if (iq_en) gain_q <= step_q;
        end
        AGC_LOCK: if (win_end) begin
          if (iq_en) begin
            gain_i <= step_lock;
            gain_q <= step_lock;
          end else begin
            gain_i <= step_i;
          end
        end
        AGC_DIRECT: begin
          gain_i <= direct_gain;
          if (iq_en) gain_q <= direct_gain;
        end
        default: ;
      endcase
    end
  end

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (mode_e != AGC_DIRECT) |=> ((gain_i == $past(gain_i)) ||
                                (gain_i == $past(gain_i) + 1'b1) ||
                                (gain_i == $past(gain_i) - 1'b1)));

  a_r4_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
    (mode_e != AGC_DIRECT && gain_i == TOP) |=> (gain_i != '0));

  a_r4_no_wrap_bottom: assert property (@(posedge clk) disable iff (rst)
    (mode_e != AGC_DIRECT && gain_i == '0) |=> (gain_i != TOP));

  a_r2_window_only: assert property (@(posedge clk) disable iff (rst)
    (mode_e != AGC_DIRECT && !win_end) |=> ($stable(gain_i) && $stable(gain_q)));

  a_r6_locked_equal: assert property (@(posedge clk) disable iff (rst)
    (mode_e == AGC_LOCK && iq_en && win_end) |=> (gain_i == gain_q));

  a_r7_direct_load: assert property (@(posedge clk) disable iff (rst)
    (mode_e == AGC_DIRECT) |=> (gain_i == $past(direct_gain)));

  a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
    (mode_e == AGC_FREEZE) |=> ($stable(gain_i) && $stable(gain_q)));

  a_r9_q_idle: assert property (@(posedge clk) disable iff (rst)
    !iq_en |=> $stable(gain_q));
endmodule

// File: tb/tb_mag_agc.sv
module tb_mag_agc;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode;
  logic       iq_en;
  logic [11:0] ref_count;
  logic [5:0] direct_gain;
  logic       mag_i, mag_q;
  logic [5:0] gain_i, gain_q;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  mag_agc dut (
    .clk(clk), .rst(rst), .mode(mode), .iq_en(iq_en), .ref_count(ref_count),
    .direct_gain(direct_gain), .mag_i(mag_i), .mag_q(mag_q),
    .gain_i(gain_i), .gain_q(gain_q)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Forces a restart (mode 11 for one edge, then the target mode), so that a
  // full window starts on the next edge.
  task automatic begin_window(input logic [1:0] m);
    mag_i = 1'b0; mag_q = 1'b0;
    mode = 2'b11; tick();
    mode = m;     tick();
  endtask

  // One full window: the first ni samples have I set, the first nq have Q set.
  task automatic run_window(input int ni, input int nq);
    int gi0, gq0;
    gi0 = gain_i; gq0 = gain_q;
    for (int k = 0; k < 512; k++) begin
      if (k == 511) begin
        check("R2 I before window end", gain_i, gi0);
        check("R2 Q before window end", gain_q, gq0);
      end
      mag_i = (k < ni); mag_q = (k < nq);
      tick();
    end
    mag_i = 1'b0; mag_q = 1'b0;
  endtask

  task automatic load_direct(input int g);
    direct_gain = 6'(g); mode = 2'b10; tick();
  endtask

  task automatic t_reset();
    check("R1 I reset", gain_i, 58);
    check("R1 Q reset", gain_q, 58);
  endtask

  task automatic t_split();
    iq_en = 1'b1; ref_count = 12'd170;
    begin_window(2'b00);
    run_window(100, 200);
    check("R3 R5 I up", gain_i, 59);
    check("R3 R5 Q down", gain_q, 57);
    run_window(170, 170);
    check("R3 I equal holds", gain_i, 59);
    check("R3 Q equal holds", gain_q, 57);
  endtask

  task automatic t_direct_sat();
    load_direct(63);
    check("R7 I direct", gain_i, 63);
    check("R7 Q direct", gain_q, 63);
    begin_window(2'b00);
    run_window(0, 0);
    check("R4 I top saturate", gain_i, 63);
    check("R4 Q top saturate", gain_q, 63);
    load_direct(0);
    begin_window(2'b00);
    run_window(512, 512);
    check("R4 I bottom saturate", gain_i, 0);
    check("R4 Q bottom saturate", gain_q, 0);
  endtask

  task automatic t_locked();
    load_direct(20);
    begin_window(2'b01);
    run_window(100, 200);
    check("R6 I locked up", gain_i, 21);
    check("R6 Q locked up", gain_q, 21);
    run_window(60, 300);  // sum 360 > 340: down, though I alone is low
    check("R6 I locked by sum", gain_i, 20);
    check("R6 Q locked by sum", gain_q, 20);
  endtask

  task automatic t_freeze();
    begin_window(2'b11);
    run_window(0, 512);
    check("R8 I hold", gain_i, 20);
    check("R8 Q hold", gain_q, 20);
  endtask

  task automatic t_iq_off();
    iq_en = 1'b0;
    begin_window(2'b00);
    run_window(0, 0);
    check("R9 I still loops", gain_i, 21);
    check("R9 Q holds", gain_q, 20);
    load_direct(40);
    check("R9 I direct", gain_i, 40);
    check("R9 Q ignores direct", gain_q, 20);
    iq_en = 1'b1;
  endtask

  task automatic t_restart();
    begin_window(2'b00);
    for (int k = 0; k < 300; k++) begin
      mag_i = 1'b0; mag_q = 1'b0; tick();
    end
    mode = 2'b11; tick();
    mode = 2'b00; tick();
    check("R10 I after partial", gain_i, 40);
    run_window(170, 170);
    check("R10 I partial not judged", gain_i, 40);
    check("R10 Q partial not judged", gain_q, 20);
  endtask

  initial begin
    rst = 1'b1; mode = 2'b00; iq_en = 1'b1; ref_count = 12'd170;
    direct_gain = 6'd58; mag_i = 1'b0; mag_q = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_split();
    t_direct_sat();
    t_locked();
    t_freeze();
    t_iq_off();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule